// File: doc/BRIEF.md
# SIMT Divergence Reconvergence Stack

This block follows branch divergence for one group of lanes that execute in lockstep. It holds a stack of entries. Each entry keeps a program counter, the address at which the split paths rejoin (the reconvergence PC), and a mask with one bit per lane. The top entry always drives the visible PC, the reconvergence PC and the execution mask. The lane predicate used at issue is the top mask ANDed with an initial mask that is latched when the group is launched.

A launch request loads the stack with one base entry. When a divergent branch occurs, the sequencer sends one request that pushes two entries at once. The fall-through entry goes in first and the taken entry goes in on top of it, so the taken path runs first. Both entries carry the branch's reconvergence PC. When the running path reaches its reconvergence PC, which the block signals by matching the top PC against the top reconvergence PC, the sequencer requests a pop. The entry underneath then becomes visible. A PC write advances the top entry within a path.

Every request takes effect at the next clock edge. When a push does not fit, or a pop would remove the base entry, the request is dropped and a sticky flag is raised. A new launch clears both flags. The lane count may only be 16, 32 or 64. Elaboration stops with an error for any other value.

Top module: `simt_reconv_stack`

## Requirements
- R1: After reset, depth_o is 0 and pc_o, rpc_o, exec_mask_o, pred_o, at_reconv_o, overflow_o and underflow_o are all 0. While depth_o is 0, a branch request or a PC write changes nothing.
- R2: A launch (start_i) takes effect on the next edge: depth_o becomes 1, pc_o becomes start_pc_i, rpc_o becomes all ones, exec_mask_o and the latched initial mask both become start_mask_i, and both flags clear.
- R3: An accepted branch raises depth_o by 2 on the next edge. The top becomes {br_taken_pc_i, br_rpc_i, br_taken_mask_i}. The entry beneath it is {br_fall_pc_i, br_rpc_i, br_fall_mask_i}.
- R4: An accepted pop lowers depth_o by 1 on the next edge and exposes the entry beneath, including any PC written into that entry while it was on top.
- R5: A PC write replaces only pc_o with pc_wr_data_i on the next edge. rpc_o, exec_mask_o and depth_o keep their values.
- R6: When a pop and a PC write are requested in the same cycle, the pop is carried out and the PC write is dropped.
- R7: A branch request when depth_o + 2 exceeds DEPTH is dropped, leaving depth and outputs unchanged, and sets overflow_o. overflow_o stays set until the next launch.
- R8: A pop request when depth_o is below 2 is dropped, leaving depth and outputs unchanged, and sets underflow_o. underflow_o stays set until the next launch.
- R9: pred_o always equals exec_mask_o ANDed with the mask latched at the last launch.
- R10: Priority is launch, then pop, then branch, then PC write. A lower-priority request that arrives together with a higher one is dropped and raises no flag.
- R11: at_reconv_o is 1 exactly when depth_o is nonzero and pc_o equals rpc_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch the group and load the base entry |
| start_pc_i | input | PC_W | First PC of the group |
| start_mask_i | input | LANES | Initial lane mask |
| branch_i | input | 1 | Divergent branch: push fall-through, then taken |
| br_taken_pc_i | input | PC_W | Target PC of the taken path |
| br_taken_mask_i | input | LANES | Lanes on the taken path |
| br_fall_pc_i | input | PC_W | PC of the fall-through path |
| br_fall_mask_i | input | LANES | Lanes on the fall-through path |
| br_rpc_i | input | PC_W | Reconvergence PC stored in both pushed entries |
| pop_i | input | 1 | Remove the top entry |
| pc_wr_i | input | 1 | Overwrite the top entry's PC |
| pc_wr_data_i | input | PC_W | New PC for the top entry |
| pc_o | output | PC_W | PC of the top entry |
| rpc_o | output | PC_W | Reconvergence PC of the top entry |
| exec_mask_o | output | LANES | Execution mask of the top entry |
| pred_o | output | LANES | Issue predicate: top mask AND initial mask |
| at_reconv_o | output | 1 | Top PC has reached its reconvergence PC |
| depth_o | output | $clog2(DEPTH+1) | Number of live entries |
| overflow_o | output | 1 | Sticky: a branch was dropped for lack of room |
| underflow_o | output | 1 | Sticky: a pop would have removed the base entry |

## Verification
The main collision is a pop and a PC write in the same cycle. Both target the top entry, and the pop must win. The bench provokes this with a directed step right after a branch and then by driving pop_i and pc_wr_i independently at random, so the two often coincide. A reference stack in the bench applies the launch, pop, branch, PC-write priority. Every output is compared on the falling edge after the request: pc_o must show the entry that was underneath and not the written value, and depth_o must drop by exactly one. A branch arriving together with a pop is judged in the same way. It must neither push nor raise overflow_o.

// File: rtl/srs_pkg.sv
package srs_pkg;

  // Operation chosen for the current cycle after priority resolution.
  typedef enum logic [2:0] {
    SRS_IDLE,
    SRS_START,
    SRS_POP,
    SRS_BRANCH,
    SRS_PCWR
  } srs_op_e;

  // Only these lane counts are supported.
  function automatic bit lanes_ok(int unsigned n);
    return (n == 16) || (n == 32) || (n == 64);
  endfunction

  // A divergent branch needs two free slots.
  function automatic logic pair_fits(int unsigned d, int unsigned cap);
    return (d + 2) <= cap;
  endfunction

  // A pop must leave the base entry in place.
  function automatic logic pop_ok(int unsigned d);
    return d >= 2;
  endfunction

  // The issue predicate.
  function automatic logic [63:0] lane_pred(logic [63:0] top_mask, logic [63:0] init_mask);
    return top_mask & init_mask;
  endfunction

endpackage

// File: rtl/srs_arbiter.sv
module srs_arbiter #(
  parameter int DEPTH = 16,
  localparam int DW = $clog2(DEPTH + 1)
) (
  input  logic                  start_i,
  input  logic                  pop_i,
  input  logic                  branch_i,
  input  logic                  pc_wr_i,
  input  logic [DW-1:0]         depth_i,
  output srs_pkg::srs_op_e      op_o,
  output logic                  ovf_evt_o,
  output logic                  unf_evt_o
);
  import srs_pkg::*;

  logic live;
  logic room;
  logic can_pop;

  assign live    = (depth_i != '0);
  assign room    = pair_fits(int'(depth_i), DEPTH);
  assign can_pop = pop_ok(int'(depth_i));

  always_comb begin
    op_o      = SRS_IDLE;
    ovf_evt_o = 1'b0;
    unf_evt_o = 1'b0;
    if (start_i) begin
      op_o = SRS_START;
    end else if (pop_i) begin
      if (can_pop) op_o = SRS_POP;
      else         unf_evt_o = 1'b1;
    end else if (branch_i) begin
      if (live) begin
        if (room) op_o = SRS_BRANCH;
        else      ovf_evt_o = 1'b1;
      end
    end else if (pc_wr_i && live) begin
      op_o = SRS_PCWR;
    end
  end

endmodule

// File: rtl/srs_entry_store.sv
module srs_entry_store #(
  parameter int LANES = 64,
  parameter int DEPTH = 16,
  parameter int PC_W  = 32,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we0_i,
  input  logic [IW-1:0]     idx0_i,
  input  logic [PC_W-1:0]   pc0_i,
  input  logic [PC_W-1:0]   rpc0_i,
  input  logic [LANES-1:0]  mask0_i,
  input  logic              we1_i,
  input  logic [IW-1:0]     idx1_i,
  input  logic [PC_W-1:0]   pc1_i,
  input  logic [PC_W-1:0]   rpc1_i,
  input  logic [LANES-1:0]  mask1_i,
  input  logic [IW-1:0]     rd_idx_i,
  output logic [PC_W-1:0]   rd_pc_o,
  output logic [PC_W-1:0]   rd_rpc_o,
  output logic [LANES-1:0]  rd_mask_o
);

  logic [PC_W-1:0]  pc_mem   [DEPTH];
  logic [PC_W-1:0]  rpc_mem  [DEPTH];
  logic [LANES-1:0] mask_mem [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    logic hit0;
    logic hit1;
    assign hit0 = we0_i && (idx0_i == IW'(e));
    assign hit1 = we1_i && (idx1_i == IW'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pc_mem[e]   <= '0;
        rpc_mem[e]  <= '0;
        mask_mem[e] <= '0;
      end else if (hit0) begin
        pc_mem[e]   <= pc0_i;
        rpc_mem[e]  <= rpc0_i;
        mask_mem[e] <= mask0_i;
      end else if (hit1) begin
        pc_mem[e]   <= pc1_i;
        rpc_mem[e]  <= rpc1_i;
        mask_mem[e] <= mask1_i;
      end
    end
  end

  assign rd_pc_o   = pc_mem[rd_idx_i];
  assign rd_rpc_o  = rpc_mem[rd_idx_i];
  assign rd_mask_o = mask_mem[rd_idx_i];

endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack #(
  parameter int LANES = 64,
  parameter int DEPTH = 16,
  parameter int PC_W  = 32,
  localparam int DW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [PC_W-1:0]   start_pc_i,
  input  logic [LANES-1:0]  start_mask_i,
  input  logic              branch_i,
  input  logic [PC_W-1:0]   br_taken_pc_i,
  input  logic [LANES-1:0]  br_taken_mask_i,
  input  logic [PC_W-1:0]   br_fall_pc_i,
  input  logic [LANES-1:0]  br_fall_mask_i,
  input  logic [PC_W-1:0]   br_rpc_i,
  input  logic              pop_i,
  input  logic              pc_wr_i,
  input  logic [PC_W-1:0]   pc_wr_data_i,
  output logic [PC_W-1:0]   pc_o,
  output logic [PC_W-1:0]   rpc_o,
  output logic [LANES-1:0]  exec_mask_o,
  output logic [LANES-1:0]  pred_o,
  output logic              at_reconv_o,
  output logic [DW-1:0]     depth_o,
  output logic              overflow_o,
  output logic              underflow_o
);
  import srs_pkg::*;

  localparam int IW = $clog2(DEPTH);

  if (!lanes_ok(LANES)) begin : g_bad_lanes
    $error("simt_reconv_stack: LANES must be 16, 32 or 64");
  end
  if (DEPTH < 3) begin : g_bad_depth
    $error("simt_reconv_stack: DEPTH must be at least 3");
  end

  // State
  logic [DW-1:0]    depth_q;
  logic [PC_W-1:0]  top_pc_q;
  logic [PC_W-1:0]  top_rpc_q;
  logic [LANES-1:0] top_mask_q;
  logic [LANES-1:0] init_q;
  logic             ovf_q;
  logic             unf_q;

  // Decoded events, named for the checker
  srs_op_e op;
  logic    do_start;
  logic    do_pop;
  logic    do_branch;
  logic    do_pcwr;
  logic    ovf_evt;
  logic    unf_evt;

  srs_arbiter #(.DEPTH(DEPTH)) u_arb (
    .start_i   (start_i),
    .pop_i     (pop_i),
    .branch_i  (branch_i),
    .pc_wr_i   (pc_wr_i),
    .depth_i   (depth_q),
    .op_o      (op),
    .ovf_evt_o (ovf_evt),
    .unf_evt_o (unf_evt)
  );

  assign do_start  = (op == SRS_START);
  assign do_pop    = (op == SRS_POP);
  assign do_branch = (op == SRS_BRANCH);
  assign do_pcwr   = (op == SRS_PCWR);

  // Slot indices
  logic [IW-1:0] top_idx;
  logic [IW-1:0] below_idx;
  logic [IW-1:0] free_idx;
  logic [IW-1:0] free2_idx;

  assign top_idx   = IW'(depth_q - DW'(1));
  assign below_idx = IW'(depth_q - DW'(2));
  assign free_idx  = IW'(depth_q);
  assign free2_idx = IW'(depth_q + DW'(1));

  // Store write ports
  logic             we0;
  logic [IW-1:0]    idx0;
  logic [PC_W-1:0]  pc0;
  logic [PC_W-1:0]  rpc0;
  logic [LANES-1:0] mask0;
  logic [PC_W-1:0]  rd_pc;
  logic [PC_W-1:0]  rd_rpc;
  logic [LANES-1:0] rd_mask;

  always_comb begin
    we0   = 1'b0;
    idx0  = '0;
    pc0   = '0;
    rpc0  = '0;
    mask0 = '0;
    unique case (op)
      SRS_START: begin
        we0   = 1'b1;
        idx0  = '0;
        pc0   = start_pc_i;
        rpc0  = '1;
        mask0 = start_mask_i;
      end
      SRS_BRANCH: begin
        we0   = 1'b1;
        idx0  = free_idx;
        pc0   = br_fall_pc_i;
        rpc0  = br_rpc_i;
        mask0 = br_fall_mask_i;
      end
      SRS_PCWR: begin
        we0   = 1'b1;
        idx0  = top_idx;
        pc0   = pc_wr_data_i;
        rpc0  = top_rpc_q;
        mask0 = top_mask_q;
      end
      default: ;
    endcase
  end

  srs_entry_store #(.LANES(LANES), .DEPTH(DEPTH), .PC_W(PC_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .we0_i     (we0),
    .idx0_i    (idx0),
    .pc0_i     (pc0),
    .rpc0_i    (rpc0),
    .mask0_i   (mask0),
    .we1_i     (do_branch),
    .idx1_i    (free2_idx),
    .pc1_i     (br_taken_pc_i),
    .rpc1_i    (br_rpc_i),
    .mask1_i   (br_taken_mask_i),
    .rd_idx_i  (below_idx),
    .rd_pc_o   (rd_pc),
    .rd_rpc_o  (rd_rpc),
    .rd_mask_o (rd_mask)
  );

  // Next values for the registered top copy
  logic [DW-1:0]    depth_d;
  logic [PC_W-1:0]  top_pc_d;
  logic [PC_W-1:0]  top_rpc_d;
  logic [LANES-1:0] top_mask_d;

  always_comb begin
    depth_d    = depth_q;
    top_pc_d   = top_pc_q;
    top_rpc_d  = top_rpc_q;
    top_mask_d = top_mask_q;
    unique case (op)
      SRS_START: begin
        depth_d    = DW'(1);
        top_pc_d   = start_pc_i;
        top_rpc_d  = '1;
        top_mask_d = start_mask_i;
      end
      SRS_POP: begin
        depth_d    = depth_q - DW'(1);
        top_pc_d   = rd_pc;
        top_rpc_d  = rd_rpc;
        top_mask_d = rd_mask;
      end
      SRS_BRANCH: begin
        depth_d    = depth_q + DW'(2);
        top_pc_d   = br_taken_pc_i;
        top_rpc_d  = br_rpc_i;
        top_mask_d = br_taken_mask_i;
      end
      SRS_PCWR: begin
        top_pc_d   = pc_wr_data_i;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth_q    <= '0;
      top_pc_q   <= '0;
      top_rpc_q  <= '0;
      top_mask_q <= '0;
      init_q     <= '0;
      ovf_q      <= 1'b0;
      unf_q      <= 1'b0;
    end else begin
      depth_q    <= depth_d;
      top_pc_q   <= top_pc_d;
      top_rpc_q  <= top_rpc_d;
      top_mask_q <= top_mask_d;
      if (do_start) begin
        init_q <= start_mask_i;
        ovf_q  <= 1'b0;
        unf_q  <= 1'b0;
      end else begin
        if (ovf_evt) ovf_q <= 1'b1;
        if (unf_evt) unf_q <= 1'b1;
      end
    end
  end

  logic [63:0] pred_wide;
  assign pred_wide = lane_pred(64'(top_mask_q), 64'(init_q));

  assign pc_o        = top_pc_q;
  assign rpc_o       = top_rpc_q;
  assign exec_mask_o = top_mask_q;
  assign pred_o      = pred_wide[LANES-1:0];
  assign at_reconv_o = (depth_q != '0) && (top_pc_q == top_rpc_q);
  assign depth_o     = depth_q;
  assign overflow_o  = ovf_q;
  assign underflow_o = unf_q;

endmodule

// File: rtl/srs_checker.sv
module srs_checker #(
  parameter int LANES = 64,
  parameter int DEPTH = 16,
  parameter int PC_W  = 32,
  localparam int DW   = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [PC_W-1:0]   start_pc_i,
  input logic [LANES-1:0]  start_mask_i,
  input logic [PC_W-1:0]   br_taken_pc_i,
  input logic [PC_W-1:0]   br_rpc_i,
  input logic              pop_i,
  input logic              pc_wr_i,
  input logic [PC_W-1:0]   pc_wr_data_i,
  input logic [PC_W-1:0]   pc_o,
  input logic [PC_W-1:0]   rpc_o,
  input logic [LANES-1:0]  exec_mask_o,
  input logic [LANES-1:0]  pred_o,
  input logic [DW-1:0]     depth_o,
  input logic              overflow_o,
  input logic              underflow_o,
  input logic              do_start,
  input logic              do_pop,
  input logic              do_branch,
  input logic              do_pcwr,
  input logic              ovf_evt,
  input logic              unf_evt
);

  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    do_start |=> (depth_o == DW'(1)) && (pc_o == $past(start_pc_i)) && (rpc_o == '1)
                 && (pred_o == $past(start_mask_i)) && !overflow_o && !underflow_o); // R2

  AST_PUSH_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    do_branch |=> (depth_o == $past(depth_o) + DW'(2)) && (pc_o == $past(br_taken_pc_i))
                  && (rpc_o == $past(br_rpc_i))); // R3

  AST_POP_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    do_pop |=> (depth_o == $past(depth_o) - DW'(1))); // R4

  AST_PCWR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    do_pcwr |=> (pc_o == $past(pc_wr_data_i)) && $stable(rpc_o) && $stable(exec_mask_o)
                && $stable(depth_o)); // R5

  AST_POP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && pc_wr_i && !start_i && (depth_o >= DW'(2))) |=> (depth_o == $past(depth_o) - DW'(1))); // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> overflow_o && $stable(depth_o) && $stable(pc_o)); // R7

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow_o && !start_i) |=> overflow_o); // R7

  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    depth_o <= DW'(DEPTH)); // R7

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    unf_evt |=> underflow_o && $stable(depth_o) && $stable(pc_o)); // R8

  AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow_o && !start_i) |=> underflow_o); // R8

  AST_PRED_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_o & ~exec_mask_o) == '0); // R9

  AST_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({do_start, do_pop, do_branch, do_pcwr, ovf_evt, unf_evt})); // R10

endmodule

bind simt_reconv_stack srs_checker #(.LANES(LANES), .DEPTH(DEPTH), .PC_W(PC_W)) u_srs_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_i       (start_i),
  .start_pc_i    (start_pc_i),
  .start_mask_i  (start_mask_i),
  .br_taken_pc_i (br_taken_pc_i),
  .br_rpc_i      (br_rpc_i),
  .pop_i         (pop_i),
  .pc_wr_i       (pc_wr_i),
  .pc_wr_data_i  (pc_wr_data_i),
  .pc_o          (pc_o),
  .rpc_o         (rpc_o),
  .exec_mask_o   (exec_mask_o),
  .pred_o        (pred_o),
  .depth_o       (depth_o),
  .overflow_o    (overflow_o),
  .underflow_o   (underflow_o),
  .do_start      (do_start),
  .do_pop        (do_pop),
  .do_branch     (do_branch),
  .do_pcwr       (do_pcwr),
  .ovf_evt       (ovf_evt),
  .unf_evt       (unf_evt)
);

// File: tb/simt_reconv_stack_test.sv
`timescale 1ns/1ps
module simt_reconv_stack_test;
  localparam int L  = 64;
  localparam int D  = 16;
  localparam int P  = 32;
  localparam int DW = $clog2(D + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 0;
  logic [P-1:0]  start_pc_i = '0;
  logic [L-1:0]  start_mask_i = '0;
  logic          branch_i = 0;
  logic [P-1:0]  br_taken_pc_i = '0;
  logic [L-1:0]  br_taken_mask_i = '0;
  logic [P-1:0]  br_fall_pc_i = '0;
  logic [L-1:0]  br_fall_mask_i = '0;
  logic [P-1:0]  br_rpc_i = '0;
  logic          pop_i = 0;
  logic          pc_wr_i = 0;
  logic [P-1:0]  pc_wr_data_i = '0;
  logic [P-1:0]  pc_o, rpc_o;
  logic [L-1:0]  exec_mask_o, pred_o;
  logic          at_reconv_o;
  logic [DW-1:0] depth_o;
  logic          overflow_o, underflow_o;

  always #2 clk = ~clk;

  simt_reconv_stack #(.LANES(L), .DEPTH(D), .PC_W(P)) uut (.*);

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference model
  logic [P-1:0] m_pc   [D];
  logic [P-1:0] m_rpc  [D];
  logic [L-1:0] m_mask [D];
  logic [L-1:0] m_init = '0;
  int           m_d = 0;
  bit           m_ovf = 0, m_unf = 0;
  string        last_op = "R1";

  function automatic logic [L-1:0] want_pred(logic [L-1:0] m, logic [L-1:0] i);
    return m & i;
  endfunction

  task automatic model_step();
    if (start_i) begin
      m_d = 1; m_pc[0] = start_pc_i; m_rpc[0] = '1; m_mask[0] = start_mask_i;
      m_init = start_mask_i; m_ovf = 0; m_unf = 0; last_op = "R2";
    end else if (pop_i) begin
      if (m_d >= 2) begin m_d = m_d - 1; last_op = pc_wr_i ? "R6" : "R4"; end
      else begin m_unf = 1; last_op = "R8"; end
    end else if (branch_i) begin
      if (m_d == 0) last_op = "R1";
      else if (m_d + 2 <= D) begin
        m_pc[m_d] = br_fall_pc_i; m_rpc[m_d] = br_rpc_i; m_mask[m_d] = br_fall_mask_i;
        m_pc[m_d+1] = br_taken_pc_i; m_rpc[m_d+1] = br_rpc_i; m_mask[m_d+1] = br_taken_mask_i;
        m_d = m_d + 2; last_op = "R3";
      end else begin m_ovf = 1; last_op = "R7"; end
    end else if (pc_wr_i) begin
      if (m_d != 0) begin m_pc[m_d-1] = pc_wr_data_i; last_op = "R5"; end
      else last_op = "R1";
    end else last_op = "R9";
  endtask

  task automatic compare(string tag);
    logic [P-1:0] e_pc, e_rpc;
    logic [L-1:0] e_mask;
    bit e_at;
    e_pc = '0; e_rpc = '0; e_mask = '0;
    if (m_d > 0) begin e_pc = m_pc[m_d-1]; e_rpc = m_rpc[m_d-1]; e_mask = m_mask[m_d-1]; end
    e_at = (m_d != 0) && (e_pc == e_rpc);
    checks++;
    if (pc_o !== e_pc || rpc_o !== e_rpc || exec_mask_o !== e_mask ||
        pred_o !== want_pred(e_mask, m_init) || depth_o !== DW'(m_d) ||
        overflow_o !== m_ovf || underflow_o !== m_unf || at_reconv_o !== e_at) begin
      fails++;
      $display("FAIL %s: pc=%h/%h rpc=%h/%h mask=%h/%h pred=%h/%h depth=%0d/%0d ovf=%b/%b unf=%b/%b at=%b/%b (actual/expected)",
               tag, pc_o, e_pc, rpc_o, e_rpc, exec_mask_o, e_mask, pred_o, want_pred(e_mask, m_init),
               depth_o, m_d, overflow_o, m_ovf, underflow_o, m_unf, at_reconv_o, e_at);
    end
  endtask

  task automatic idle();
    start_i = 0; branch_i = 0; pop_i = 0; pc_wr_i = 0;
  endtask

  // Inputs were set at a falling edge; apply one rising edge and check at the next falling edge.
  task automatic cycle(string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(tag);
    idle();
  endtask

  task automatic set_branch(logic [P-1:0] tpc, logic [L-1:0] tm, logic [P-1:0] fpc,
                            logic [L-1:0] fm, logic [P-1:0] rpc);
    branch_i = 1; br_taken_pc_i = tpc; br_taken_mask_i = tm;
    br_fall_pc_i = fpc; br_fall_mask_i = fm; br_rpc_i = rpc;
  endtask

  initial begin
    void'($urandom(32'h51AC_0BE7));
    repeat (3) @(negedge clk);
    compare("R1 reset");
    rst_n = 1;
    @(negedge clk);
    compare("R1 after reset");

    // R1: branch and PC write before any launch have no effect
    set_branch(32'h40, '1, 32'h44, '1, 32'h48);
    cycle("R1 branch before start");
    pc_wr_i = 1; pc_wr_data_i = 32'h77;
    cycle("R1 pc write before start");

    // R2 launch with a partial initial mask (R9)
    start_i = 1; start_pc_i = 32'h100; start_mask_i = 64'h0F0F_FFFF_0000_FFFF;
    cycle("R2 launch");

    set_branch(32'h200, 64'hFF00_FF00_FF00_FF00, 32'h180, 64'h00FF_00FF_00FF_00FF, 32'h300);
    cycle("R3/R9 branch taken on top");

    pc_wr_i = 1; pc_wr_data_i = 32'h204;
    cycle("R5 pc write");

    pop_i = 1; pc_wr_i = 1; pc_wr_data_i = 32'h999;
    cycle("R6 pop beats pc write");

    pc_wr_i = 1; pc_wr_data_i = 32'h300;
    cycle("R11 at reconvergence");

    pop_i = 1;
    cycle("R4 pop to base");

    pop_i = 1;
    cycle("R8 underflow");
    cycle("R8 underflow sticky");

    // R7: fill the stack, then one more branch
    for (int k = 0; k < 7; k++) begin
      set_branch(32'h1000 + k*16, 64'(k+1), 32'h2000 + k*16, 64'(k+3), 32'h3000 + k*16);
      cycle("R3 fill");
    end
    set_branch(32'hDEAD, '1, 32'hBEEF, '1, 32'hCAFE);
    cycle("R7 overflow");
    pop_i = 1;
    cycle("R7 overflow sticky after pop");

    // R10: branch together with pop -> pop only
    set_branch(32'h5000, '1, 32'h5004, '1, 32'h5008); pop_i = 1;
    cycle("R10 pop beats branch");

    start_i = 1; start_pc_i = 32'h800; start_mask_i = '1; pop_i = 1;
    cycle("R2/R10 launch clears flags");

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      start_i  = ($urandom % 100) < 2;
      pop_i    = ($urandom % 100) < 30;
      branch_i = ($urandom % 100) < 35;
      pc_wr_i  = ($urandom % 100) < 40;
      start_pc_i = $urandom; start_mask_i = {$urandom, $urandom};
      br_taken_pc_i = $urandom; br_fall_pc_i = $urandom; br_rpc_i = $urandom;
      br_taken_mask_i = {$urandom, $urandom}; br_fall_mask_i = {$urandom, $urandom};
      if (($urandom % 4 == 0) && m_d > 0) pc_wr_data_i = m_rpc[m_d-1];
      else pc_wr_data_i = $urandom;
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare({last_op, " random"});
      idle();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete (actual hung, expected done)");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

endmodule